// File: doc/BRIEF.md
# Noise-Free Median Extractor

This block computes a median for impulse-noise removal from a window of pixels. A window of `NUM_PIX` pixels arrives in one cycle with a valid strobe. Any pixel at either extreme of the pixel range (all zeros or all ones) is treated as an impulse and replaced by zero. The replaced values then pass through a fixed, pipelined compare-and-swap sorting network, which leaves the zeroed impulses at the low end of the ascending order.

The selection stage counts the clean pixels that survive. It then picks the median of those clean pixels only, skipping the zeroed entries. The block reports three things for each window: the median, the clean-pixel count (so a later stage can decide whether to grow its window), and a flag that is set when every pixel was noisy.

A new window can be accepted on every cycle. Each result appears a fixed `NUM_PIX + 2` cycles after its window, and the outputs hold their last values between results.

Top module: `noise_free_median`

## Requirements
- R1: `valid_o` is high exactly in the cycles that lie `NUM_PIX + 2` clock cycles after a cycle in which `valid_i` was sampled high. With the defaults this is 11 cycles.
- R2: An input pixel of value 0 or of value 2^`PIX_W`-1 (255 by default) is an impulse. An impulse never takes part in the count or the median, whichever lane it arrives in.
- R3: `clean_cnt_o` equals the number of input pixels of the window that are neither 0 nor 2^`PIX_W`-1.
- R4: When k, the clean count, is odd and non-zero, `median_o` is the clean pixel of rank (k-1)/2 in ascending order, counting from 0.
- R5: When k = 0, `all_noisy_o` is 1 and `median_o` is 0. When k > 0, `all_noisy_o` is 0.
- R6: Windows presented on consecutive cycles each yield their own independent result, on consecutive cycles.
- R7: While `rst_ni` is low, `valid_o`, `median_o`, `clean_cnt_o` and `all_noisy_o` are all 0.
- R8: In any cycle in which `valid_o` is low, `median_o`, `clean_cnt_o` and `all_noisy_o` keep the values they had in the previous cycle.
- R9: When k is even and non-zero, `median_o` is the lower of the two middle clean pixels, that is the rank (k-1)/2 (floor), counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Window on `pix_i` is valid this cycle |
| pix_i | input | NUM_PIX*PIX_W | Window pixels; lane g occupies bits [g*PIX_W +: PIX_W] |
| valid_o | output | 1 | Result outputs carry a new result this cycle |
| median_o | output | PIX_W | Median of the clean pixels, 0 if none |
| clean_cnt_o | output | $clog2(NUM_PIX+1) | Number of clean pixels in the window |
| all_noisy_o | output | 1 | Every pixel of the window was an impulse |

## Verification
Two things happen in the same cycle in the pipeline. The count stage takes in window n+1 while the selection stage retires window n using the count it registered for window n. A mistake in that hand-off would apply one window's count to its neighbour's sorted data.

To provoke this, the bench drives back-to-back windows whose clean counts jump between the extremes: all-noisy next to fully clean, and odd next to even. It also interleaves idle gaps, which exercise the hold behaviour. Every result is compared in its own cycle against a behavioural reference computed from that window alone, with each idle cycle checked against the last retired values.

// File: rtl/nfm_pkg.sv
package nfm_pkg;

  // width of a counter able to hold 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < (n + 1)) w++;
    return w;
  endfunction

  // position in the ascending sort of the lower clean median; impulses sit low
  function automatic int unsigned pick_index(input int unsigned n, input int unsigned k);
    if (k == 0) return 0;
    return n - k + (k - 1) / 2;
  endfunction

endpackage

// File: rtl/nfm_cas_layer.sv
module nfm_cas_layer #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned NUM_PIX = 9,
  parameter bit          ODD     = 1'b0
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_PIX-1:0][PIX_W-1:0]   d_i,
  output logic [NUM_PIX-1:0][PIX_W-1:0]   q_o
);

  localparam int FIRST = ODD ? 1 : 0;

  logic [NUM_PIX-1:0][PIX_W-1:0] nxt;

  always_comb begin
    nxt = d_i;
    for (int i = FIRST; i < int'(NUM_PIX) - 1; i += 2) begin
      if (d_i[i] > d_i[i+1]) begin
        nxt[i]   = d_i[i+1];
        nxt[i+1] = d_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end

endmodule

// File: rtl/nfm_sort_net.sv
module nfm_sort_net #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned NUM_PIX = 9
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_PIX-1:0][PIX_W-1:0]   d_i,
  output logic [NUM_PIX-1:0][PIX_W-1:0]   q_o
);

  // odd-even transposition: NUM_PIX alternating layers sort NUM_PIX values
  logic [NUM_PIX:0][NUM_PIX-1:0][PIX_W-1:0] stage;

  assign stage[0] = d_i;

  for (genvar l = 0; l < NUM_PIX; l++) begin : g_layer
    nfm_cas_layer #(
      .PIX_W  (PIX_W),
      .NUM_PIX(NUM_PIX),
      .ODD    ((l % 2) == 1)
    ) u_layer (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (stage[l]),
      .q_o   (stage[l+1])
    );
  end

  assign q_o = stage[NUM_PIX];

endmodule

// File: rtl/nfm_select.sv
module nfm_select #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned NUM_PIX = 9,
  parameter int unsigned CNT_W   = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic [NUM_PIX-1:0][PIX_W-1:0]   sorted_i,
  output logic                            valid_o,
  output logic [PIX_W-1:0]                median_o,
  output logic [CNT_W-1:0]                cnt_o,
  output logic                            all_noisy_o
);

  logic [CNT_W-1:0]              cnt_c;
  logic [NUM_PIX-1:0][PIX_W-1:0] srt_q;
  logic [CNT_W-1:0]              cnt_q;
  logic                          vld_q;
  logic [PIX_W-1:0]              pick_c;

  // count stage
  always_comb begin
    cnt_c = '0;
    for (int i = 0; i < int'(NUM_PIX); i++)
      if (sorted_i[i] != '0) cnt_c = cnt_c + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srt_q <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      srt_q <= sorted_i;
      cnt_q <= cnt_c;
      vld_q <= valid_i;
    end
  end

  // selection stage
  always_comb begin
    pick_c = '0;
    for (int i = 0; i < int'(NUM_PIX); i++)
      if ((cnt_q != '0) && (i == int'(nfm_pkg::pick_index(NUM_PIX, int'(cnt_q)))))
        pick_c = srt_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      median_o    <= '0;
      cnt_o       <= '0;
      all_noisy_o <= 1'b0;
    end else begin
      valid_o <= vld_q;
      if (vld_q) begin
        median_o    <= pick_c;
        cnt_o       <= cnt_q;
        all_noisy_o <= (cnt_q == '0);
      end
    end
  end

endmodule

// File: rtl/noise_free_median.sv
module noise_free_median #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned NUM_PIX = 9,
  localparam int unsigned CNT_W  = nfm_pkg::cnt_width(NUM_PIX)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [NUM_PIX*PIX_W-1:0]   pix_i,
  output logic                       valid_o,
  output logic [PIX_W-1:0]           median_o,
  output logic [CNT_W-1:0]           clean_cnt_o,
  output logic                       all_noisy_o
);

  logic [NUM_PIX-1:0][PIX_W-1:0] mapped;
  logic [NUM_PIX-1:0][PIX_W-1:0] sorted;
  logic [NUM_PIX-1:0]            vld_sh;

  // impulses at either rail become zero
  for (genvar g = 0; g < NUM_PIX; g++) begin : g_map
    logic [PIX_W-1:0] px;
    assign px        = pix_i[g*PIX_W +: PIX_W];
    assign mapped[g] = ((px == '0) || (px == '1)) ? '0 : px;
  end

  nfm_sort_net #(
    .PIX_W  (PIX_W),
    .NUM_PIX(NUM_PIX)
  ) u_sort (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mapped),
    .q_o   (sorted)
  );

  // valid travels beside the network layers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_sh <= '0;
    else         vld_sh <= {vld_sh[NUM_PIX-2:0], valid_i};
  end

  nfm_select #(
    .PIX_W  (PIX_W),
    .NUM_PIX(NUM_PIX),
    .CNT_W  (CNT_W)
  ) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (vld_sh[NUM_PIX-1]),
    .sorted_i   (sorted),
    .valid_o    (valid_o),
    .median_o   (median_o),
    .cnt_o      (clean_cnt_o),
    .all_noisy_o(all_noisy_o)
  );

endmodule

// File: rtl/nfm_checker.sv
module nfm_checker #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned NUM_PIX = 9,
  parameter int unsigned CNT_W   = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             valid_o,
  input logic [PIX_W-1:0] median_o,
  input logic [CNT_W-1:0] clean_cnt_o,
  input logic             all_noisy_o
);

  localparam int unsigned LAT = NUM_PIX + 2;

  logic [LAT-1:0] in_hist;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_hist <= '0;
    else         in_hist <= {in_hist[LAT-2:0], valid_i};
  end

  assert_valid_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == in_hist[LAT-1]);

  assert_no_rail_median_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !all_noisy_o) |-> (median_o != '0 && median_o != '1));

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(clean_cnt_o) <= int'(NUM_PIX)));

  assert_all_noisy_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && clean_cnt_o == '0) |-> (all_noisy_o && median_o == '0));

  assert_flag_implies_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_noisy_o |-> (clean_cnt_o == '0));

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(median_o) && $stable(clean_cnt_o) && $stable(all_noisy_o)));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R7: assert (!valid_o && median_o == '0 && clean_cnt_o == '0 && !all_noisy_o);
    end
  end

endmodule

bind noise_free_median nfm_checker #(
  .PIX_W  (PIX_W),
  .NUM_PIX(NUM_PIX),
  .CNT_W  (CNT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .valid_o    (valid_o),
  .median_o   (median_o),
  .clean_cnt_o(clean_cnt_o),
  .all_noisy_o(all_noisy_o)
);

// File: tb/noise_free_median_tb_top.sv
module noise_free_median_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP   = 9;
  localparam int PW   = 8;
  localparam int MAXV = (1 << PW) - 1;
  localparam int LAT  = NP + 2;

  typedef struct {
    bit v;
    int med;
    int cnt;
    bit flag;
    bit imp;
    bit b2b;
  } rec_t;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [NP*PW-1:0] pix_i = '0;
  logic            valid_o;
  logic [PW-1:0]   median_o;
  logic [3:0]      clean_cnt_o;
  logic            all_noisy_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit prev_v = 0;

  rec_t pipe[$];
  int held_med = 0, held_cnt = 0;
  bit held_flag = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  noise_free_median #(.PIX_W(PW), .NUM_PIX(NP)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .pix_i      (pix_i),
    .valid_o    (valid_o),
    .median_o   (median_o),
    .clean_cnt_o(clean_cnt_o),
    .all_noisy_o(all_noisy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic rec_t ref_model(input int w [NP], input bit v, input bit b2b);
    int q[$];
    rec_t r;
    r.v = v; r.imp = 0; r.b2b = b2b;
    foreach (w[i]) begin
      if (w[i] != 0 && w[i] != MAXV) q.push_back(w[i]);
      else r.imp = 1;
    end
    q.sort();
    r.cnt  = q.size();
    r.flag = (q.size() == 0);
    r.med  = (q.size() == 0) ? 0 : q[(q.size() - 1) / 2];
    return r;
  endfunction

  // one cycle: check outputs of this cycle, then drive the next input
  task automatic step(input bit v, input int w [NP]);
    rec_t e;
    @(negedge clk_i);
    if (pipe.size() == LAT) e = pipe.pop_front();
    else begin
      e.v = 0; e.med = 0; e.cnt = 0; e.flag = 0; e.imp = 0; e.b2b = 0;
    end
    chk(valid_o == e.v, "R1", int'(valid_o), int'(e.v));
    if (e.v) begin
      held_med = e.med; held_cnt = e.cnt; held_flag = e.flag;
      chk(int'(clean_cnt_o) == e.cnt, e.b2b ? "R6" : "R3", int'(clean_cnt_o), e.cnt);
      chk(all_noisy_o == e.flag, "R5", int'(all_noisy_o), int'(e.flag));
      if (e.cnt == 0)
        chk(int'(median_o) == 0, "R5", int'(median_o), 0);
      else if (e.imp)
        chk(int'(median_o) == e.med, "R2", int'(median_o), e.med);
      else if ((e.cnt % 2) == 0)
        chk(int'(median_o) == e.med, "R9", int'(median_o), e.med);
      else
        chk(int'(median_o) == e.med, "R4", int'(median_o), e.med);
    end else begin
      chk(int'(median_o) == held_med, "R8", int'(median_o), held_med);
      chk(int'(clean_cnt_o) == held_cnt, "R8", int'(clean_cnt_o), held_cnt);
      chk(all_noisy_o == held_flag, "R8", int'(all_noisy_o), int'(held_flag));
    end
    valid_i = v;
    for (int i = 0; i < NP; i++) pix_i[i*PW +: PW] = PW'(w[i]);
    pipe.push_back(ref_model(w, v, v && prev_v));
    prev_v = v;
  endtask

  task automatic win(input int a0, a1, a2, a3, a4, a5, a6, a7, a8);
    int w [NP];
    w = '{a0, a1, a2, a3, a4, a5, a6, a7, a8};
    step(1'b1, w);
  endtask

  task automatic idle();
    int w [NP];
    for (int i = 0; i < NP; i++) w[i] = int'($urandom_range(0, MAXV));
    step(1'b0, w);
  endtask

  initial begin
    // reset state: R7
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R7", int'(valid_o), 0);
    chk(int'(median_o) == 0, "R7", int'(median_o), 0);
    chk(int'(clean_cnt_o) == 0, "R7", int'(clean_cnt_o), 0);
    chk(all_noisy_o == 1'b0, "R7", int'(all_noisy_o), 0);
    rst_ni = 1'b1;

    // directed corner windows, back to back
    win(9, 3, 7, 1, 5, 8, 2, 6, 4);               // k=9 odd, R4
    win(0, 0, 0, 0, 0, 0, 0, 0, 0);               // k=0, R5
    win(255, 0, 255, 0, 255, 0, 255, 0, 255);     // k=0 mixed rails
    win(0, 255, 0, 255, 77, 0, 255, 0, 255);      // k=1
    win(0, 255, 200, 0, 0, 50, 255, 0, 0);        // k=2 lower middle, R9
    win(1, 254, 1, 254, 1, 254, 1, 254, 1);       // near-rail values are clean
    win(10, 20, 30, 40, 50, 60, 70, 80, 255);     // k=8
    win(100, 100, 100, 0, 100, 255, 100, 100, 7); // duplicates
    win(12, 34, 56, 78, 90, 11, 22, 33, 44);      // k=9 again after k=8
    idle(); idle();
    win(0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle();
    win(128, 0, 0, 0, 0, 0, 0, 0, 0);             // single clean at lane 0
    win(0, 0, 0, 0, 0, 0, 0, 0, 3);               // single clean at last lane
    win(200, 100, 255, 255, 255, 255, 255, 255, 255);

    // random windows with sweeping noise density and idle gaps
    for (int n = 0; n < 600; n++) begin
      int w [NP];
      int dens;
      dens = (n * 7) % 101;
      if ($urandom_range(0, 99) < 20) idle();
      else begin
        for (int i = 0; i < NP; i++) begin
          if (int'($urandom_range(0, 99)) < dens)
            w[i] = ($urandom_range(0, 1) == 1) ? MAXV : 0;
          else
            w[i] = int'($urandom_range(0, MAXV));
        end
        step(1'b1, w);
      end
    end

    repeat (LAT + 3) idle();

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule